// File: doc/BRIEF.md
# Key Register Access-Control Tracker

This block keeps a 5-bit permission word for each register in a bank of crypto key registers. An instruction decoder sends one request at a time to the block. A request carries an operation, a register index, the current security mode and, where the operation needs one, a permission value. The operations are: query, load from data memory, spill to data memory, load a hardware secret, permission write, and use as a key. The key data itself is not part of this block. Only the permission state and the allow/deny decisions are modelled.

For every request the block returns a registered response one clock later. The response gives the decision and the permission word of the addressed register after the operation. A denied request raises a sticky error flag. The block also records the index of the register that was denied.

The permission bits are linked to each other. Two of them can only be cleared, never set again, until reset. The bits that govern non-secure mode are forced by the bits that govern secure mode. A load writes a default word, and that default depends on the security mode.

Top module: `keyacl_tracker`

## Requirements
- R1: After reset, every register's permission word is 0x1F, the error flag is 0 and no response is valid.
- R2: Operation codes on `reqOp` are 0 query, 1 load, 2 spill, 3 secret, 4 write and 5 use. Codes 6 and 7 act as query. A request accepted on a clock edge is answered on that edge: `respValid`, `respAllow` and `respAcl` are valid until the next edge. `respAcl` is the addressed word after the operation. A query is always allowed and changes nothing.
- R3: The permission word bits are: bit0 secure-keyable, bit1 secure-readable, bit2 keyable, bit3 readable, bit4 writeable. After every update, the following forcing rules hold:
  - bit1 set forces bit0 set.
  - bit3 set forces bit2 set.
  - bit0 clear forces bit2 clear.
  - bit1 clear forces bit3 clear.
- R4: A permission write can never set bit0 or bit1 again once it is clear.
- R5: A permission write is always allowed. Subject to R3, it sets bits 2, 3 and 4 freely in either direction.
- R6: A load in secure mode is always allowed and sets the word to 0x13.
- R7: A load in non-secure mode is denied when bit4 is clear, and the word is then left unchanged. Otherwise the load sets the word to 0x1F.
- R8: A spill is allowed when bit1 is set (secure mode) or when bit3 is set (non-secure mode). A spill never changes the word.
- R9: A secret load is always allowed. It sets the word to the supplied value with the R3 forcing applied, and the one-way rule of R4 is ignored.
- R10: Use as a key is allowed when bit0 is set (secure mode) or when bit2 is set (non-secure mode). It never changes the word.
- R11: A denied request sets `errSticky`, which stays set until reset. `errIdx` holds the index of the most recent denied request.
- R12: A request changes only the word of the register it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe |
| reqOp | input | 3 | Operation code |
| reqIdx | input | IDX_W | Addressed key register |
| secureMode | input | 1 | 1 = secure mode, 0 = non-secure mode |
| reqAcl | input | 5 | Permission value for write or secret load |
| respValid | output | 1 | Response strobe |
| respAllow | output | 1 | Decision for the answered request |
| respAcl | output | 5 | Addressed word after the operation |
| errSticky | output | 1 | A request has been denied since reset |
| errIdx | output | IDX_W | Index of the latest denied request |

## Verification
The bench builds the block with its default of eight registers, so the 3-bit index field is used at full width. This makes both the lowest and the highest index reachable for the check that no other register is disturbed. Each scenario works on its own register. Each one drives that register through the chains of linked bits, which makes every forcing rule and both one-way bits observable in `respAcl`.

// File: rtl/keyacl_pkg.sv
package keyacl_pkg;
  localparam int ACL_W = 5;
  localparam logic [ACL_W-1:0] ACL_RESET = 5'h1F;
  localparam logic [ACL_W-1:0] ACL_LOAD_SEC = 5'h13;
  localparam logic [ACL_W-1:0] ACL_LOAD_NSEC = 5'h1F;

  // bit positions
  localparam int B_SKEY = 0;
  localparam int B_SRD = 1;
  localparam int B_KEY = 2;
  localparam int B_RD = 3;
  localparam int B_WR = 4;

  typedef enum logic [2:0] {
    OP_QUERY = 3'd0,
    OP_LOAD = 3'd1,
    OP_SPILL = 3'd2,
    OP_SECRET = 3'd3,
    OP_WRITE = 3'd4,
    OP_USE = 3'd5
  } opKind_e;

  typedef enum logic [1:0] {
    UPD_KEEP = 2'd0,
    UPD_DEFAULT = 2'd1,
    UPD_MERGE = 2'd2,
    UPD_FORCE = 2'd3
  } updMode_e;

  typedef struct packed {
    logic fire;
    logic apply;
    updMode_e mode;
  } ctrlStrobe_t;

  // Apply the forcing chain: secure bits dominate the non-secure ones.
  function automatic logic [ACL_W-1:0] aclCouple(input logic [ACL_W-1:0] w);
    logic sRd, sKey, rd, key;
    sRd = w[B_SRD];
    sKey = w[B_SKEY] | sRd;
    rd = w[B_RD] & sRd;
    key = (w[B_KEY] | rd) & sKey;
    return {w[B_WR], rd, key, sRd, sKey};
  endfunction
endpackage

// File: rtl/keyacl_ctrl.sv
module keyacl_ctrl
  import keyacl_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [2:0]       reqOp,
  input  logic [IDX_W-1:0] reqIdx,
  input  logic             secureMode,
  input  logic [ACL_W-1:0] curAcl,
  output ctrlStrobe_t      strobe,
  output logic             respValid,
  output logic             respAllow,
  output logic             errSticky,
  output logic [IDX_W-1:0] errIdx
);
  logic allow;
  updMode_e mode;
  logic modifies;

  always_comb begin
    allow = 1'b1;
    mode = UPD_KEEP;
    modifies = 1'b0;
    case (reqOp)
      OP_LOAD: begin
        allow = secureMode | curAcl[B_WR];
        mode = UPD_DEFAULT;
        modifies = 1'b1;
      end
      OP_SPILL: allow = secureMode ? curAcl[B_SRD] : curAcl[B_RD];
      OP_SECRET: begin
        mode = UPD_FORCE;
        modifies = 1'b1;
      end
      OP_WRITE: begin
        mode = UPD_MERGE;
        modifies = 1'b1;
      end
      OP_USE: allow = secureMode ? curAcl[B_SKEY] : curAcl[B_KEY];
      default: allow = 1'b1;
    endcase
  end

  always_comb begin
    strobe.fire = reqValid;
    strobe.apply = reqValid & allow & modifies;
    strobe.mode = mode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respAllow <= 1'b0;
      errSticky <= 1'b0;
      errIdx <= '0;
    end else begin
      respValid <= reqValid;
      if (reqValid) respAllow <= allow;
      if (reqValid && !allow) begin
        errSticky <= 1'b1;
        errIdx <= reqIdx;
      end
    end
  end
endmodule

// File: rtl/keyacl_store.sv
module keyacl_store
  import keyacl_pkg::*;
#(
  parameter int NUM_KEYS = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] reqIdx,
  input  logic             secureMode,
  input  logic [ACL_W-1:0] reqAcl,
  input  ctrlStrobe_t      strobe,
  output logic [ACL_W-1:0] curAcl,
  output logic [ACL_W-1:0] respAcl
);
  logic [ACL_W-1:0] aclMem [NUM_KEYS];
  logic [ACL_W-1:0] nextAcl;

  always_comb begin
    curAcl = ACL_RESET;
    for (int k = 0; k < NUM_KEYS; k++)
      if (reqIdx == IDX_W'(k)) curAcl = aclMem[k];
  end

  always_comb begin
    case (strobe.mode)
      UPD_DEFAULT: nextAcl = secureMode ? ACL_LOAD_SEC : ACL_LOAD_NSEC;
      UPD_MERGE: nextAcl = aclCouple({reqAcl[ACL_W-1:B_KEY],
                                      reqAcl[B_SRD] & curAcl[B_SRD],
                                      reqAcl[B_SKEY] & curAcl[B_SKEY]});
      UPD_FORCE: nextAcl = aclCouple(reqAcl);
      default: nextAcl = curAcl;
    endcase
  end

  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) aclMem[g] <= ACL_RESET;
      else if (strobe.apply && reqIdx == IDX_W'(g)) aclMem[g] <= nextAcl;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) respAcl <= ACL_RESET;
    else if (strobe.fire) respAcl <= strobe.apply ? nextAcl : curAcl;
  end
endmodule

// File: rtl/keyacl_tracker.sv
module keyacl_tracker
  import keyacl_pkg::*;
#(
  parameter int NUM_KEYS = 8,
  localparam int IDX_W = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [2:0]       reqOp,
  input  logic [IDX_W-1:0] reqIdx,
  input  logic             secureMode,
  input  logic [4:0]       reqAcl,
  output logic             respValid,
  output logic             respAllow,
  output logic [4:0]       respAcl,
  output logic             errSticky,
  output logic [IDX_W-1:0] errIdx
);
  ctrlStrobe_t strobe;
  logic [ACL_W-1:0] curAcl;

  keyacl_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqIdx(reqIdx), .secureMode(secureMode), .curAcl(curAcl),
    .strobe(strobe), .respValid(respValid), .respAllow(respAllow),
    .errSticky(errSticky), .errIdx(errIdx)
  );

  keyacl_store #(.NUM_KEYS(NUM_KEYS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rstN(rstN), .reqIdx(reqIdx), .secureMode(secureMode),
    .reqAcl(reqAcl), .strobe(strobe), .curAcl(curAcl), .respAcl(respAcl)
  );
endmodule

// File: rtl/keyacl_chk.sv
module keyacl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic [2:0] reqOp,
  input logic       secureMode,
  input logic       respValid,
  input logic       respAllow,
  input logic [4:0] respAcl,
  input logic       errSticky
);
  AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid); // R2
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid); // R2
  AST_ACL_COUPLED: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> ((!respAcl[1] || respAcl[0]) && (!respAcl[3] || respAcl[1]) &&
                   (!respAcl[3] || respAcl[2]) && (!respAcl[2] || respAcl[0]))); // R3
  AST_WRITE_ALLOWED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 3'd4) |=> respAllow); // R5
  AST_SECURE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 3'd1 && secureMode) |=> (respAllow && respAcl == 5'h13)); // R6
  AST_SECRET_ALLOWED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 3'd3) |=> respAllow); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky); // R11
  AST_DENY_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respAllow) |-> errSticky); // R11
endmodule

bind keyacl_tracker keyacl_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
  .secureMode(secureMode), .respValid(respValid), .respAllow(respAllow),
  .respAcl(respAcl), .errSticky(errSticky)
);

// File: tb/tb_keyacl_tracker.sv
`timescale 1ns/100ps
module tb_keyacl_tracker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqOp = '0;
  logic [2:0] reqIdx = '0;
  logic secureMode = 1'b0;
  logic [4:0] reqAcl = '0;
  logic respValid, respAllow, errSticky;
  logic [4:0] respAcl;
  logic [2:0] errIdx;
  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  localparam logic [2:0] Q = 3'd0, LD = 3'd1, SP = 3'd2, SEC = 3'd3, WR = 3'd4, USE = 3'd5;

  always #2.5 clk = ~clk;

  keyacl_tracker #(.NUM_KEYS(8)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqIdx(reqIdx),
    .secureMode(secureMode), .reqAcl(reqAcl), .respValid(respValid),
    .respAllow(respAllow), .respAcl(respAcl), .errSticky(errSticky), .errIdx(errIdx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Issue one request, then check the registered response.
  task automatic req(input logic [2:0] op, input int idx, input logic sec,
                     input logic [4:0] acl, input logic expAllow,
                     input logic [4:0] expAcl, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqIdx = 3'(idx); secureMode = sec; reqAcl = acl;
    @(negedge clk);
    reqValid = 1'b0;
    chk({tag, " valid"}, int'(respValid), 1);
    chk({tag, " allow"}, int'(respAllow), int'(expAllow));
    chk({tag, " acl"}, int'(respAcl), int'(expAcl));
  endtask

  task automatic tReset();
    chk("R1 respValid after reset", int'(respValid), 0);
    chk("R1 errSticky after reset", int'(errSticky), 0);
    req(Q, 0, 1'b0, 5'h00, 1'b1, 5'h1F, "R1 R2 query idx0");
    req(3'd7, 7, 1'b1, 5'h00, 1'b1, 5'h1F, "R1 R2 query idx7 code7");
  endtask

  task automatic tWriteRules();
    req(WR, 1, 1'b0, 5'h1B, 1'b1, 5'h1F, "R3 bit3 forces bit2");
    req(WR, 1, 1'b0, 5'h05, 1'b1, 5'h05, "R5 clear bits 1 3 4");
    req(WR, 1, 1'b0, 5'h1F, 1'b1, 5'h15, "R4 bit1 one-way, R3 bit3 clear");
    req(WR, 1, 1'b0, 5'h1A, 1'b1, 5'h10, "R3 bit0 clear forces bit2 clear");
    req(WR, 1, 1'b1, 5'h1F, 1'b1, 5'h10, "R4 bit0 one-way");
    req(WR, 1, 1'b0, 5'h00, 1'b1, 5'h00, "R5 bit4 clear");
    req(WR, 1, 1'b0, 5'h10, 1'b1, 5'h10, "R5 bit4 set again");
  endtask

  task automatic tToggle();
    req(WR, 2, 1'b0, 5'h17, 1'b1, 5'h17, "R5 bit3 clear");
    req(WR, 2, 1'b0, 5'h1F, 1'b1, 5'h1F, "R5 bit3 set again");
    req(WR, 2, 1'b0, 5'h13, 1'b1, 5'h13, "R5 bit2 clear");
    req(WR, 2, 1'b0, 5'h17, 1'b1, 5'h17, "R5 bit2 set again");
  endtask

  task automatic tLoads();
    req(WR, 3, 1'b0, 5'h0F, 1'b1, 5'h0F, "R5 clear writeable");
    chk("R11 no error before deny", int'(errSticky), 0);
    req(LD, 3, 1'b0, 5'h00, 1'b0, 5'h0F, "R7 non-secure load denied");
    chk("R11 error raised", int'(errSticky), 1);
    chk("R11 error index", int'(errIdx), 3);
    req(LD, 3, 1'b1, 5'h00, 1'b1, 5'h13, "R6 secure load");
    req(LD, 3, 1'b0, 5'h00, 1'b1, 5'h1F, "R7 non-secure load");
  endtask

  task automatic tSpill();
    req(LD, 4, 1'b1, 5'h00, 1'b1, 5'h13, "R6 secure load idx4");
    req(SP, 4, 1'b0, 5'h00, 1'b0, 5'h13, "R8 non-secure spill denied");
    req(SP, 4, 1'b1, 5'h00, 1'b1, 5'h13, "R8 secure spill");
    req(WR, 4, 1'b1, 5'h11, 1'b1, 5'h11, "R4 drop secure-readable");
    req(SP, 4, 1'b1, 5'h00, 1'b0, 5'h11, "R8 secure spill denied");
    chk("R11 error index spill", int'(errIdx), 4);
  endtask

  task automatic tSecret();
    req(WR, 5, 1'b0, 5'h00, 1'b1, 5'h00, "R5 clear all");
    req(SEC, 5, 1'b0, 5'h13, 1'b1, 5'h13, "R9 secret ignores one-way");
    req(SEC, 5, 1'b1, 5'h01, 1'b1, 5'h01, "R9 secret value");
    req(SEC, 5, 1'b0, 5'h0A, 1'b1, 5'h0F, "R9 secret forced coupling");
  endtask

  task automatic tUse();
    req(USE, 6, 1'b1, 5'h00, 1'b1, 5'h1F, "R10 secure use");
    req(WR, 6, 1'b0, 5'h13, 1'b1, 5'h13, "R5 drop keyable");
    req(USE, 6, 1'b0, 5'h00, 1'b0, 5'h13, "R10 non-secure use denied");
    req(USE, 6, 1'b1, 5'h00, 1'b1, 5'h13, "R10 secure use kept");
    req(WR, 6, 1'b1, 5'h10, 1'b1, 5'h10, "R4 drop secure bits");
    req(USE, 6, 1'b1, 5'h00, 1'b0, 5'h10, "R10 secure use denied");
  endtask

  task automatic tIsolation();
    req(Q, 0, 1'b0, 5'h00, 1'b1, 5'h1F, "R12 idx0 untouched");
    req(Q, 7, 1'b0, 5'h00, 1'b1, 5'h1F, "R12 idx7 untouched");
    req(Q, 3, 1'b0, 5'h00, 1'b1, 5'h1F, "R12 idx3 holds own value");
    chk("R11 error stays set", int'(errSticky), 1);
    chk("R11 latest error index", int'(errIdx), 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tWriteRules();
    tToggle();
    tLoads();
    tSpill();
    tSecret();
    tUse();
    tIsolation();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end
endmodule